// File: doc/BRIEF.md
# Flash Status Toggle-Bit Generator

This block produces the bit 6 status flag on the read data path of an embedded flash controller while the internal program or erase sequence is in progress. Software polls the array with ordinary reads. While an operation runs, each new read access returns the opposite of the previous one. When the flag stops changing, the poller knows the operation has finished. During an erase suspend, the value depends on where the read lands: reads inside the sector being erased return a constant 1, and reads elsewhere return the stored data.

The controller reports the start of each operation, its kind (program or erase), and whether every target sector is write-protected. It also reports normal completion and the suspend level. When all targets are protected, the block times the operation itself. It keeps toggling for a fixed window (2 µs for a program, 100 µs for an erase), derived from the clock frequency. It then returns to ready without any data being touched. A ready output rises in the same cycle that toggling ends.

Top module: `flash_toggle_status`

## Requirements
- R1: After reset, `ready` is 1 and `dq6` is 0.
- R2: After `op_start`, `ready` is 0. The first read access returns `dq6` = 0, and each later access returns the inverse of the one before, regardless of `array_bit6`.
- R3: Only a rising edge of `rd_strobe` counts as an access. A strobe held high for several cycles yields one value, and `dq6` keeps its value between accesses.
- R4: When `algo_done` is asserted during an operation, `ready` is 1 from the next cycle. Later reads return `array_bit6`.
- R5: During an erase with `erase_suspend` high, a read with `sector_hit` = 1 returns `dq6` = 1.
- R6: During a suspended erase, a read with `sector_hit` = 0 returns `array_bit6`. After `erase_suspend` falls, toggling continues from the value of the last toggling read before the suspend.
- R7: A program started with `targets_prot` = 1 toggles on reads. `ready` rises exactly PROG_PROT_US × CLK_HZ / 10^6 cycles (250 at defaults) after the cycle in which `op_start` was sampled.
- R8: An erase started with `targets_prot` = 1 toggles on reads. `ready` rises exactly ERASE_PROT_US × CLK_HZ / 10^6 cycles (12500 at defaults) after `op_start` is sampled.
- R9: While ready, reads return `array_bit6`, and `sector_hit` has no effect.
- R10: During a program, `erase_suspend` is ignored and reads keep toggling.
- R11: An `op_start` during a running operation restarts the sequence, so the next read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle pulse: a program or erase begins |
| op_erase | input | 1 | Kind of the starting operation: 1 = erase, 0 = program |
| targets_prot | input | 1 | All targets of the starting operation are write-protected |
| algo_done | input | 1 | Internal algorithm finished normally |
| erase_suspend | input | 1 | Level: the running erase is suspended |
| rd_strobe | input | 1 | Read access strobe; an access is its rising edge |
| sector_hit | input | 1 | Read address lies in a sector being erased |
| array_bit6 | input | 1 | Bit 6 of the array data at the read address |
| dq6 | output | 1 | Status bit 6 returned for the last access, updated one cycle after the strobe edge |
| ready | output | 1 | 1 when no operation is running |

## Verification
All four combinations of `sector_hit` and `array_bit6` are swept in the ready state and again while an erase is suspended. This separates the data pass-through from the forced 1 of a hit sector. Toggling reads run over alternating and constant array data, which shows that the flag ignores the stored bit. A strobe held for several cycles distinguishes per-access toggling from per-clock toggling. Protected program and erase runs are timed to the exact cycle, with reads interleaved, to confirm that the timeout windows are independent of read traffic.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    typedef struct packed {
        run_st_e st;
        logic    erase;
        logic    tgl;
        logic    dq6;
    } core_regs_t;

endpackage

// File: rtl/ftg_strobe_edge.sv
module ftg_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic prev_d;
    logic prev_q;

    always_comb begin
        prev_d = strobe;
        rise   = strobe & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/ftg_prot_timer.sv
module ftg_prot_timer #(
    parameter int PROG_CYC  = 250,
    parameter int ERASE_CYC = 12500,
    parameter int CNT_W     = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_erase,
    input  logic load_prot,
    input  logic hold,
    output logic expire
);
    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d;
    tmr_regs_t tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = 1'b0;
        if (load) begin
            tmr_d.armed = load_prot;
            tmr_d.cnt   = load_erase ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
        end else if (tmr_q.armed && !hold) begin
            if (tmr_q.cnt == '0) begin
                expire      = 1'b1;
                tmr_d.armed = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/ftg_status_core.sv
module ftg_status_core
    import ftg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic op_erase,
    input  logic algo_done,
    input  logic tmr_expire,
    input  logic erase_suspend,
    input  logic rd_rise,
    input  logic sector_hit,
    input  logic array_bit6,
    output logic susp_active,
    output logic dq6,
    output logic ready
);
    core_regs_t r_d;
    core_regs_t r_q;

    always_comb begin
        r_d         = r_q;
        susp_active = (r_q.st == ST_RUN) && r_q.erase && erase_suspend;

        // value returned for a new access
        if (rd_rise) begin
            if (r_q.st == ST_IDLE) begin
                r_d.dq6 = array_bit6;
            end else if (susp_active) begin
                r_d.dq6 = sector_hit ? 1'b1 : array_bit6;
            end else begin
                r_d.dq6 = r_q.tgl;
                r_d.tgl = ~r_q.tgl;
            end
        end

        // operation sequencing; a new start wins over everything
        if (op_start) begin
            r_d.st    = ST_RUN;
            r_d.erase = op_erase;
            r_d.tgl   = 1'b0;
        end else if ((r_q.st == ST_RUN) && (algo_done || tmr_expire)) begin
            r_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, erase: 1'b0, tgl: 1'b0, dq6: 1'b0};
        else        r_q <= r_d;
    end

    assign dq6   = r_q.dq6;
    assign ready = (r_q.st == ST_IDLE);
endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status #(
    parameter int CLK_HZ        = 125_000_000,
    parameter int PROG_PROT_US  = 2,
    parameter int ERASE_PROT_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic op_erase,
    input  logic targets_prot,
    input  logic algo_done,
    input  logic erase_suspend,
    input  logic rd_strobe,
    input  logic sector_hit,
    input  logic array_bit6,
    output logic dq6,
    output logic ready
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int PROG_CYC   = CYC_PER_US * PROG_PROT_US;
    localparam int ERASE_CYC  = CYC_PER_US * ERASE_PROT_US;
    localparam int MAX_CYC    = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    logic rd_rise;
    logic tmr_expire;
    logic susp_active;

    ftg_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_strobe),
        .rise   (rd_rise)
    );

    ftg_prot_timer #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (op_start),
        .load_erase (op_erase),
        .load_prot  (targets_prot),
        .hold       (susp_active),
        .expire     (tmr_expire)
    );

    ftg_status_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_start      (op_start),
        .op_erase      (op_erase),
        .algo_done     (algo_done),
        .tmr_expire    (tmr_expire),
        .erase_suspend (erase_suspend),
        .rd_rise       (rd_rise),
        .sector_hit    (sector_hit),
        .array_bit6    (array_bit6),
        .susp_active   (susp_active),
        .dq6           (dq6),
        .ready         (ready)
    );
endmodule

// File: rtl/ftg_checker.sv
module ftg_checker (
    input logic clk,
    input logic rst_n,
    input logic op_start,
    input logic op_erase,
    input logic algo_done,
    input logic erase_suspend,
    input logic rd_strobe,
    input logic sector_hit,
    input logic array_bit6,
    input logic dq6,
    input logic ready
);
    logic prev_rd_q;
    logic erase_q;
    logic lt_valid_q;
    logic lt_val_q;
    logic rd_new;
    logic susp_now;
    logic tog_read;
    logic exp_tog;

    assign rd_new   = rd_strobe && !prev_rd_q;
    assign susp_now = !ready && erase_q && erase_suspend;
    assign tog_read = rd_new && !ready && !susp_now && !op_start;
    assign exp_tog  = lt_valid_q ? ~lt_val_q : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_rd_q  <= 1'b0;
            erase_q    <= 1'b0;
            lt_valid_q <= 1'b0;
            lt_val_q   <= 1'b0;
        end else begin
            prev_rd_q <= rd_strobe;
            if (op_start) begin
                erase_q    <= op_erase;
                lt_valid_q <= 1'b0;
            end else if (tog_read) begin
                lt_valid_q <= 1'b1;
                lt_val_q   <= exp_tog;
            end
        end
    end

    p_toggle_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tog_read |=> (dq6 == $past(exp_tog)));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !ready);

    p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_new |=> $stable(dq6));

    p_done_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (algo_done && !ready && !op_start) |=> ready);

    p_susp_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_new && susp_now && sector_hit && !op_start) |=> dq6);

    p_susp_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_new && susp_now && !sector_hit && !op_start) |=> (dq6 == $past(array_bit6)));

    p_idle_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_new && ready && !op_start) |=> (dq6 == $past(array_bit6)));
endmodule

bind flash_toggle_status ftg_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_start      (op_start),
    .op_erase      (op_erase),
    .algo_done     (algo_done),
    .erase_suspend (erase_suspend),
    .rd_strobe     (rd_strobe),
    .sector_hit    (sector_hit),
    .array_bit6    (array_bit6),
    .dq6           (dq6),
    .ready         (ready)
);

// File: tb/flash_toggle_status_tb.sv
`timescale 1ns/1ps
module flash_toggle_status_tb;
    localparam int CLK_MHZ   = 125;
    localparam int PROG_N    = CLK_MHZ * 2;
    localparam int ERASE_N   = CLK_MHZ * 100;
    localparam int WATCHDOG  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0, op_erase = 1'b0, targets_prot = 1'b0, algo_done = 1'b0;
    logic erase_suspend = 1'b0, rd_strobe = 1'b0, sector_hit = 1'b0, array_bit6 = 1'b0;
    logic dq6, ready;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic exp_t;
    bit   done  = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_toggle_status u_dut (
        .clk (clk), .rst_n (rst_n), .op_start (op_start), .op_erase (op_erase),
        .targets_prot (targets_prot), .algo_done (algo_done),
        .erase_suspend (erase_suspend), .rd_strobe (rd_strobe),
        .sector_hit (sector_hit), .array_bit6 (array_bit6),
        .dq6 (dq6), .ready (ready)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one access: strobe rises at a negedge, result sampled one cycle later
    task automatic rd(input logic hit, input logic b6, input logic exp, input string req);
        @(negedge clk);
        sector_hit = hit; array_bit6 = b6; rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check(req, dq6, exp);
    endtask

    task automatic start_op(input logic er, input logic prot);
        @(negedge clk);
        op_start = 1'b1; op_erase = er; targets_prot = prot;
        @(negedge clk);
        op_start = 1'b0;
        exp_t = 1'b0;
    endtask

    task automatic tog_rd(input logic b6, input string req);
        rd(1'b0, b6, exp_t, req);
        exp_t = ~exp_t;
    endtask

    task automatic finish_op(input string req);
        @(negedge clk);
        algo_done = 1'b1;
        @(negedge clk);
        algo_done = 1'b0;
        check(req, ready, 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", ready, 1);
        check("R1 dq6", dq6, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 idle: all hit/data combinations pass data through
        for (int h = 0; h < 2; h++)
            for (int b = 0; b < 2; b++)
                rd(h[0], b[0], b[0], "R9 idle read");

        // R2 program toggling over several data patterns
        start_op(1'b0, 1'b0);
        check("R2 busy", ready, 0);
        for (int i = 0; i < 6; i++) tog_rd(i[0], "R2 toggle alt data");
        for (int i = 0; i < 3; i++) tog_rd(1'b1, "R2 toggle const data");

        // R3 held strobe counts once
        @(negedge clk);
        sector_hit = 1'b0; rd_strobe = 1'b1;
        @(negedge clk);
        check("R3 held first", dq6, exp_t);
        repeat (4) @(negedge clk);
        check("R3 held stable", dq6, exp_t);
        rd_strobe = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 no access stable", dq6, exp_t);
        exp_t = ~exp_t;
        tog_rd(1'b0, "R3 next access");

        // R10 suspend ignored during program
        erase_suspend = 1'b1;
        rd(1'b1, 1'b0, exp_t, "R10 program ignores suspend"); exp_t = ~exp_t;
        rd(1'b1, 1'b1, exp_t, "R10 program ignores suspend"); exp_t = ~exp_t;
        erase_suspend = 1'b0;

        // R4 normal completion
        finish_op("R4 ready after done");
        rd(1'b0, 1'b1, 1'b1, "R4 data after done");
        rd(1'b0, 1'b0, 1'b0, "R4 data after done");

        // erase, suspend sweep, resume
        start_op(1'b1, 1'b0);
        tog_rd(1'b1, "R2 erase toggle");
        tog_rd(1'b1, "R2 erase toggle");
        tog_rd(1'b0, "R2 erase toggle");
        erase_suspend = 1'b1;
        for (int h = 0; h < 2; h++)
            for (int b = 0; b < 2; b++)
                rd(h[0], b[0], h[0] ? 1'b1 : b[0], h[0] ? "R5 suspend hit" : "R6 suspend miss");
        check("R5 busy while suspended", ready, 0);
        erase_suspend = 1'b0;
        tog_rd(1'b0, "R6 resume continues");
        tog_rd(1'b0, "R6 resume continues");

        // R11 restart mid-operation
        start_op(1'b1, 1'b0);
        tog_rd(1'b1, "R11 restart first read");
        tog_rd(1'b1, "R11 restart second read");
        finish_op("R4 erase done");

        // R7 protected program timeout
        start_op(1'b0, 1'b1);
        t0 = cyc;
        tog_rd(1'b1, "R7 protected toggles");
        tog_rd(1'b1, "R7 protected toggles");
        while (!ready) @(negedge clk);
        check("R7 window cycles", cyc - t0, PROG_N);
        rd(1'b0, 1'b1, 1'b1, "R7 data after timeout");

        // R8 protected erase timeout
        start_op(1'b1, 1'b1);
        t0 = cyc;
        tog_rd(1'b0, "R8 protected toggles");
        tog_rd(1'b0, "R8 protected toggles");
        tog_rd(1'b0, "R8 protected toggles");
        while (!ready) @(negedge clk);
        check("R8 window cycles", cyc - t0, ERASE_N);
        rd(1'b1, 1'b0, 1'b0, "R8 data after timeout");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule